// File: doc/BRIEF.md
# Subword Register Write Coalescing Bridge

This bridge sits in front of a peripheral register file that only understands aligned 32-bit reads and writes. The host side issues byte, halfword or word requests over a valid/ready channel. Byte and halfword writes become read-modify-write sequences on the downstream side. Word writes go straight through.

Some peripherals drop a write that follows another one too closely. To avoid that, two groups of halfword registers are parked in shadow words instead of being written one at a time. The first group is block size and block count, which share the word at 0x04. The second is the transfer mode at 0x0C. When a halfword write to the command register at 0x0E arrives, the block word is released first. The transfer-mode/command word follows as a second 32-bit write.

While the card clock is slow, every downstream write is followed by a quiet interval. Its length is four card-clock periods, rounded up to whole microseconds. A card clock programmed as zero gets a fixed interval instead.

Top module: `subword_wr_bridge`

## Requirements
- R1: While reset is asserted and right after it, `up_ready` is 1 and `dn_valid` and `up_rvalid` are 0. Reset clears both shadow words to zero and marks both shadows empty, so later reads of shadowed registers go downstream and a later command write flushes nothing.
- R2: A word write (`up_size` 2 or 3) issues one downstream write of `up_wdata` at the address with bits [1:0] cleared. A word read returns the downstream word unchanged.
- R3: A byte write (`up_size` 0) reads the aligned word, replaces bits [8*a+7 : 8*a] with `up_wdata[7:0]` (a = `up_addr[1:0]`) and writes the whole word back. A byte read returns that lane in `up_rdata[7:0]`, with the upper bits zero.
- R4: A halfword write (`up_size` 1) to any address other than 0x04, 0x06, 0x0C or 0x0E does a read-modify-write of bits [8*a+15 : 8*a]. A halfword read returns that lane in `up_rdata[15:0]`.
- R5: A halfword write to 0x04 or 0x06 while the block shadow is empty reads word 0x04 and merges into it. The result is kept in the block shadow, which becomes valid, and no downstream write is made.
- R6: A halfword write to 0x04 or 0x06 while the block shadow is valid merges into the shadow with no downstream access at all, and `up_ready` stays 1.
- R7: A halfword write to 0x0C always reads word 0x0C downstream and merges into it. The result goes into the command shadow, which becomes valid, and nothing is written.
- R8: A halfword write to 0x0E proceeds in this order:
  - If the block shadow is valid, it is first written to address 0x04.
  - The command halfword is then merged into the command shadow, and the result is written to address 0x0C.
  - Both shadows end up empty.
- R9: A halfword read of 0x0C is served from the command shadow while that shadow is valid. A halfword read of 0x04 or 0x06 is served from the block shadow while it is valid. All other reads, including byte and word reads of those words, come from downstream.
- R10: When `card_clk_hz` is between 1 and 400000, each downstream write is followed by ceil(4000000 / `card_clk_hz`) microseconds (times SYS_CLK_HZ/1e6 cycles). During that time there is no downstream request and `up_ready` stays 0.
- R11: When `card_clk_hz` is 0, the interval after each downstream write is 10 microseconds.
- R12: When `card_clk_hz` is above 400000, there is no interval after a write: the next downstream write of a flush is presented in the following cycle.
- R13: Only one downstream access is in flight, and `up_ready` is 0 while a read-modify-write, a flush or an interval is running. A downstream request holds its address, data and direction until `dn_ready`. Downstream addresses are always word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Host request valid |
| up_ready | output | 1 | Bridge accepts a request |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| up_addr | input | AW | Byte address |
| up_wdata | input | 32 | Write value, lane in the low bits |
| up_rvalid | output | 1 | One-cycle read response strobe |
| up_rdata | output | 32 | Read value, lane in the low bits |
| card_clk_hz | input | 32 | Configured card clock in Hz |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts request |
| dn_write | output | 1 | Downstream request is a write |
| dn_addr | output | AW | Aligned downstream address |
| dn_wdata | output | 32 | Downstream write word |
| dn_rvalid | input | 1 | Downstream read data strobe |
| dn_rdata | input | 32 | Downstream read word |

## Verification
Several properties are checked every cycle:
- downstream addresses stay aligned;
- a pending downstream request stays frozen until accepted;
- a downstream request never coexists with `up_ready`;
- a write taken at a slow card clock is followed by a quiet cycle;
- a block-shadow hit makes no downstream access;
- a command write leaves both shadows empty and starts a write.

The merged word contents and the flush order can only be shown by the bench's scoreboard of expected downstream writes and read data, across many scenarios. So can the exact interval lengths at 400000, 300000, 100000, 0 and 400001 Hz, the data returned from the shadows, and the shadows being cleared by a mid-run reset.

// File: rtl/subword_wr_bridge.sv
module subword_wr_bridge #(
  parameter int AW              = 8,
  parameter int SYS_CLK_HZ      = 50_000_000,
  parameter int SLOW_HZ_LIMIT   = 400_000,
  parameter int GAP_PERIODS     = 4,
  parameter int ZERO_CLK_GAP_US = 10,
  parameter int BLK_SIZE_ADDR   = 'h04,
  parameter int BLK_CNT_ADDR    = 'h06,
  parameter int XFER_ADDR       = 'h0C,
  parameter int CMD_ADDR        = 'h0E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic          up_write,
  input  logic [1:0]    up_size,
  input  logic [AW-1:0] up_addr,
  input  logic [31:0]   up_wdata,
  output logic          up_rvalid,
  output logic [31:0]   up_rdata,
  input  logic [31:0]   card_clk_hz,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic [31:0]   dn_wdata,
  input  logic          dn_rvalid,
  input  logic [31:0]   dn_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_GAP} state_t;
  typedef enum logic [1:0] {OP_READ, OP_RMW, OP_BLK, OP_XFER} op_t;

  localparam int            TPU        = SYS_CLK_HZ / 1_000_000;
  localparam int            DIVW       = (TPU > 1) ? $clog2(TPU) : 1;
  localparam logic [32:0]   GAP_BUDGET = 33'(GAP_PERIODS) * 33'd1_000_000;
  localparam logic [31:0]   ZERO_STEP  = 32'(GAP_PERIODS * 1_000_000 / ZERO_CLK_GAP_US);
  localparam logic [31:0]   SLOW_LIMIT = 32'(SLOW_HZ_LIMIT);
  localparam logic [AW-1:0] A_BSZ      = AW'(BLK_SIZE_ADDR);
  localparam logic [AW-1:0] A_BCNT     = AW'(BLK_CNT_ADDR);
  localparam logic [AW-1:0] A_XFER     = AW'(XFER_ADDR);
  localparam logic [AW-1:0] A_CMD      = AW'(CMD_ADDR);
  localparam logic [AW-1:0] A_BLK_WORD = {A_BSZ[AW-1:2], 2'b00};
  localparam logic [AW-1:0] A_CMD_WORD = {A_CMD[AW-1:2], 2'b00};

  function automatic logic [31:0] lane_mask(input logic [1:0] sz, input logic [4:0] sh);
    logic [31:0] m;
    m = sz[1] ? 32'hFFFF_FFFF : (sz[0] ? 32'h0000_FFFF : 32'h0000_00FF);
    return m << sh;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] val,
                                        input logic [1:0] sz, input logic [4:0] sh);
    return (old & ~lane_mask(sz, sh)) | ((val << sh) & lane_mask(sz, sh));
  endfunction

  function automatic logic [31:0] extract(input logic [31:0] w, input logic [1:0] sz,
                                          input logic [4:0] sh);
    return (w >> sh) & lane_mask(sz, 5'd0);
  endfunction

  state_t        st;
  op_t           op;
  logic [1:0]    lat_size;
  logic [4:0]    lat_sh;
  logic [31:0]   lat_val;
  logic [AW-1:0] dn_addr_q;
  logic [31:0]   dn_wdata_q;
  logic          pend_cmd;
  logic [31:0]   pend_word;
  logic [31:0]   blk_sh, cmd_sh;
  logic          blk_v, cmd_v;
  logic          rvalid_q;
  logic [31:0]   rdata_q;
  logic [DIVW-1:0] div_cnt;
  logic [31:0]   acc, step_q;

  assign up_ready  = (st == S_IDLE);
  assign dn_valid  = (st == S_RD_REQ) || (st == S_WR_REQ);
  assign dn_write  = (st == S_WR_REQ);
  assign dn_addr   = dn_addr_q;
  assign dn_wdata  = dn_wdata_q;
  assign up_rvalid = rvalid_q;
  assign up_rdata  = rdata_q;

  wire          req      = up_valid && up_ready;
  wire [4:0]    req_sh   = up_size[1] ? 5'd0 : {up_addr[1:0], 3'b000};
  wire [AW-1:0] req_word = {up_addr[AW-1:2], 2'b00};
  wire          half     = (up_size == 2'd1);
  wire          hit_blk  = half && (up_addr == A_BSZ || up_addr == A_BCNT);
  wire          hit_xfer = half && (up_addr == A_XFER);
  wire          hit_cmd  = half && (up_addr == A_CMD);
  wire          slow_clk = (card_clk_hz <= SLOW_LIMIT);
  wire [31:0]   clk_step = (card_clk_hz == 32'd0) ? ZERO_STEP : card_clk_hz;
  wire          tick     = (div_cnt == DIVW'(TPU - 1));
  wire          budget_hit = ({1'b0, acc} + {1'b0, step_q}) >= GAP_BUDGET;
  wire          wr_retire  = (st == S_WR_REQ && dn_ready && !slow_clk) ||
                             (st == S_GAP && tick && budget_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  op <= OP_READ;
      lat_size <= '0; lat_sh <= '0; lat_val <= '0;
      dn_addr_q <= '0; dn_wdata_q <= '0;
      pend_cmd <= 1'b0; pend_word <= '0;
      blk_sh <= '0; cmd_sh <= '0; blk_v <= 1'b0; cmd_v <= 1'b0;
      rvalid_q <= 1'b0; rdata_q <= '0;
      div_cnt <= '0; acc <= '0; step_q <= '0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (st)
        S_IDLE: if (req) begin
          lat_size <= up_size;
          lat_sh   <= req_sh;
          lat_val  <= up_wdata;
          if (up_write) begin
            if (up_size[1]) begin
              dn_addr_q  <= req_word;
              dn_wdata_q <= up_wdata;
              st         <= S_WR_REQ;
            end else if (hit_cmd) begin
              cmd_v <= 1'b0;
              if (blk_v) begin
                blk_v      <= 1'b0;
                dn_addr_q  <= A_BLK_WORD;
                dn_wdata_q <= blk_sh;
                pend_cmd   <= 1'b1;
                pend_word  <= merge(cmd_sh, up_wdata, up_size, req_sh);
              end else begin
                dn_addr_q  <= A_CMD_WORD;
                dn_wdata_q <= merge(cmd_sh, up_wdata, up_size, req_sh);
              end
              st <= S_WR_REQ;
            end else if (hit_blk && blk_v) begin
              blk_sh <= merge(blk_sh, up_wdata, up_size, req_sh);
            end else begin
              dn_addr_q <= req_word;
              op        <= hit_blk ? OP_BLK : (hit_xfer ? OP_XFER : OP_RMW);
              st        <= S_RD_REQ;
            end
          end else begin
            if (hit_xfer && cmd_v) begin
              rvalid_q <= 1'b1;
              rdata_q  <= extract(cmd_sh, up_size, req_sh);
            end else if (hit_blk && blk_v) begin
              rvalid_q <= 1'b1;
              rdata_q  <= extract(blk_sh, up_size, req_sh);
            end else begin
              dn_addr_q <= req_word;
              op        <= OP_READ;
              st        <= S_RD_REQ;
            end
          end
        end
        S_RD_REQ: if (dn_ready) st <= S_RD_WAIT;
        S_RD_WAIT: if (dn_rvalid) begin
          unique case (op)
            OP_READ: begin
              rvalid_q <= 1'b1;
              rdata_q  <= extract(dn_rdata, lat_size, lat_sh);
              st       <= S_IDLE;
            end
            OP_RMW: begin
              dn_wdata_q <= merge(dn_rdata, lat_val, lat_size, lat_sh);
              st         <= S_WR_REQ;
            end
            OP_BLK: begin
              blk_sh <= merge(dn_rdata, lat_val, lat_size, lat_sh);
              blk_v  <= 1'b1;
              st     <= S_IDLE;
            end
            default: begin
              cmd_sh <= merge(dn_rdata, lat_val, lat_size, lat_sh);
              cmd_v  <= 1'b1;
              st     <= S_IDLE;
            end
          endcase
        end
        S_WR_REQ: if (dn_ready && slow_clk) begin
          st      <= S_GAP;
          div_cnt <= '0;
          acc     <= '0;
          step_q  <= clk_step;
        end
        S_GAP: begin
          if (tick) begin
            div_cnt <= '0;
            if (!budget_hit) acc <= acc + step_q;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (wr_retire) begin
        if (pend_cmd) begin
          pend_cmd   <= 1'b0;
          dn_addr_q  <= A_CMD_WORD;
          dn_wdata_q <= pend_word;
          st         <= S_WR_REQ;
        end else begin
          st <= S_IDLE;
        end
      end
    end
  end

  AST_DN_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> dn_addr[1:0] == 2'b00);                                           // R13
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_wdata) && $stable(dn_write)); // R13
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !up_ready);                                                       // R13
  AST_SLOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_ready && dn_write && (card_clk_hz <= SLOW_LIMIT) |=> !dn_valid && !up_ready); // R10
  AST_BLK_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready && up_write && hit_blk && blk_v |=> !dn_valid && up_ready); // R6
  AST_CMD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_ready && up_write && hit_cmd |=> !blk_v && !cmd_v && dn_valid && dn_write); // R8

endmodule

// File: tb/test_subword_wr_bridge.sv
module test_subword_wr_bridge;
  localparam int TPU = 50;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        up_valid = 1'b0, up_write = 1'b0;
  logic [1:0]  up_size = 2'd0;
  logic [7:0]  up_addr = '0;
  logic [31:0] up_wdata = '0, card_clk_hz = 32'd25_000_000;
  logic        up_ready, up_rvalid;
  logic [31:0] up_rdata;
  logic        dn_valid, dn_write, dn_ready = 1'b1, dn_rvalid = 1'b0;
  logic [7:0]  dn_addr;
  logic [31:0] dn_wdata, dn_rdata = '0;

  subword_wr_bridge #(.AW(8), .SYS_CLK_HZ(50_000_000)) i_subword_wr_bridge (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
    .up_size(up_size), .up_addr(up_addr), .up_wdata(up_wdata), .up_rvalid(up_rvalid),
    .up_rdata(up_rdata), .card_clk_hz(card_clk_hz), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rvalid(dn_rvalid),
    .dn_rdata(dn_rdata));

  always #10 clk = ~clk;

  typedef struct { logic [7:0] addr; logic [31:0] data; int gap; string req; } wr_exp_t;
  typedef struct { logic [31:0] data; string req; } rd_exp_t;
  wr_exp_t wr_q[$];
  rd_exp_t rd_q[$];
  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [64];
  logic [31:0] rmem [64];
  logic [31:0] m_blk = '0, m_cmd = '0;
  logic        m_bv = 1'b0, m_cv = 1'b0;
  logic        stall = 1'b0;
  int unsigned cyc = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(input logic [1:0] sz, input logic [4:0] sh);
    logic [31:0] m;
    m = sz[1] ? 32'hFFFF_FFFF : (sz[0] ? 32'h0000_FFFF : 32'h0000_00FF);
    return m << sh;
  endfunction

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] v,
                                      input logic [1:0] sz, input logic [4:0] sh);
    return (o & ~lmask(sz, sh)) | ((v << sh) & lmask(sz, sh));
  endfunction

  function automatic int gap_cycles(input logic [31:0] hz);
    if (hz == 0) return 10 * TPU;
    if (hz <= 32'd400_000) return int'((32'd4_000_000 + hz - 1) / hz) * TPU;
    return 0;
  endfunction

  task automatic push_wr(input logic [7:0] a, input logic [31:0] d, input string req);
    wr_exp_t e;
    e.addr = a; e.data = d; e.gap = gap_cycles(card_clk_hz); e.req = req;
    wr_q.push_back(e);
    rmem[a[7:2]] = d;
  endtask

  task automatic push_rd(input logic [31:0] d, input string req);
    rd_exp_t e;
    e.data = d; e.req = req;
    rd_q.push_back(e);
  endtask

  // Downstream ready pattern, changed mid high phase
  initial forever begin
    @(posedge clk); #5;
    cyc++;
    dn_ready = !stall || (cyc % 3 == 0);
  end

  // Downstream read responder
  initial forever begin
    @(negedge clk);
    if (rst_n && dn_valid && dn_ready && !dn_write) begin
      logic [7:0] a;
      a = dn_addr;
      @(negedge clk);
      dn_rvalid = 1'b1;
      dn_rdata  = mem[a[7:2]];
      @(negedge clk);
      dn_rvalid = 1'b0;
    end
  end

  // Monitor: downstream writes and the quiet interval after each
  initial begin
    @(negedge clk);
    forever begin
      if (rst_n && dn_valid && dn_ready && dn_write) begin
        wr_exp_t e;
        logic    have;
        int      g;
        have = (wr_q.size() != 0);
        if (have) begin
          e = wr_q.pop_front();
          chk(e.req, "dn_addr", {24'b0, dn_addr}, {24'b0, e.addr});
          chk(e.req, "dn_wdata", dn_wdata, e.data);
        end else begin
          n_chk++; n_fail++;
          $display("FAIL R13 unexpected downstream write: actual %h@%h expected none", dn_wdata, dn_addr);
        end
        mem[dn_addr[7:2]] = dn_wdata;
        g = 0;
        @(negedge clk);
        while (!dn_valid && !up_ready) begin
          g++;
          @(negedge clk);
        end
        if (have) chk(e.req, "quiet cycles", 32'(g), 32'(e.gap));
      end else begin
        @(negedge clk);
      end
    end
  end

  // Monitor: upstream read responses
  initial forever begin
    @(negedge clk);
    if (rst_n && up_rvalid) begin
      if (rd_q.size() != 0) begin
        rd_exp_t e;
        e = rd_q.pop_front();
        chk(e.req, "up_rdata", up_rdata, e.data);
      end else begin
        n_chk++; n_fail++;
        $display("FAIL R13 unexpected read response: actual %h expected none", up_rdata);
      end
    end
  end

  // Driver: computes expectations from the requirements, then issues the request
  task automatic op(input logic wr, input logic [1:0] sz, input logic [7:0] a,
                    input logic [31:0] d, input string req);
    logic [4:0]  sh;
    logic [5:0]  wi;
    logic        hf, busy;
    logic [31:0] nv;
    sh = sz[1] ? 5'd0 : {a[1:0], 3'b000};
    wi = a[7:2];
    hf = (sz == 2'd1);
    busy = 1'b1;
    if (wr) begin
      if (sz[1]) push_wr({a[7:2], 2'b00}, d, req);                       // R2
      else if (hf && a == 8'h0E) begin                                   // R8
        if (m_bv) begin push_wr(8'h04, m_blk, req); m_bv = 1'b0; end
        nv = mrg(m_cmd, d, sz, sh);
        m_cv = 1'b0;
        push_wr(8'h0C, nv, req);
      end else if (hf && (a == 8'h04 || a == 8'h06)) begin               // R5 R6
        if (m_bv) begin m_blk = mrg(m_blk, d, sz, sh); busy = 1'b0; end
        else m_blk = mrg(rmem[1], d, sz, sh);
        m_bv = 1'b1;
      end else if (hf && a == 8'h0C) begin                               // R7
        m_cmd = mrg(rmem[3], d, sz, sh);
        m_cv = 1'b1;
      end else begin                                                     // R3 R4
        push_wr({a[7:2], 2'b00}, mrg(rmem[wi], d, sz, sh), req);
      end
    end else begin                                                       // R9
      if (hf && a == 8'h0C && m_cv) begin
        push_rd((m_cmd >> sh) & lmask(sz, 5'd0), req); busy = 1'b0;
      end else if (hf && (a == 8'h04 || a == 8'h06) && m_bv) begin
        push_rd((m_blk >> sh) & lmask(sz, 5'd0), req); busy = 1'b0;
      end else begin
        push_rd((rmem[wi] >> sh) & lmask(sz, 5'd0), req);
      end
    end
    up_valid = 1'b1; up_write = wr; up_size = sz; up_addr = a; up_wdata = d;
    while (!up_ready) @(negedge clk);
    @(negedge clk);
    up_valid = 1'b0;
    chk("R13", "up_ready after accept", {31'b0, up_ready}, {31'b0, !busy});
    while (!up_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_bv = 1'b0; m_cv = 1'b0; m_blk = '0; m_cmd = '0;
    repeat (2) @(negedge clk);
    chk("R1", "up_ready in reset", {31'b0, up_ready}, 32'd1);
    chk("R1", "dn_valid in reset", {31'b0, dn_valid}, 32'd0);
    chk("R1", "up_rvalid in reset", {31'b0, up_rvalid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R13 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i]  = 32'h0F1E_2D3C ^ (32'(i) * 32'h0101_0101);
      rmem[i] = mem[i];
    end
    @(negedge clk);
    do_reset();                                                          // R1
    chk("R1", "up_ready after reset", {31'b0, up_ready}, 32'd1);

    op(1'b1, 2'd2, 8'h20, 32'h1122_3344, "R2");
    op(1'b0, 2'd2, 8'h20, 32'h0, "R2");
    op(1'b0, 2'd2, 8'h23, 32'h0, "R2");
    op(1'b1, 2'd0, 8'h21, 32'hFFFF_FFAB, "R3");
    op(1'b1, 2'd0, 8'h23, 32'h0000_005C, "R3");
    op(1'b0, 2'd0, 8'h21, 32'h0, "R3");
    op(1'b0, 2'd0, 8'h22, 32'h0, "R3");
    op(1'b0, 2'd2, 8'h20, 32'h0, "R3");
    op(1'b1, 2'd1, 8'h12, 32'h0000_BEEF, "R4");
    op(1'b1, 2'd1, 8'h10, 32'h0000_1234, "R4");
    op(1'b0, 2'd1, 8'h12, 32'h0, "R4");

    stall = 1'b1;
    op(1'b1, 2'd1, 8'h04, 32'h0000_0200, "R5");
    op(1'b0, 2'd1, 8'h04, 32'h0, "R9");
    op(1'b1, 2'd1, 8'h06, 32'h0000_0008, "R6");
    op(1'b1, 2'd1, 8'h04, 32'h0000_0040, "R6");
    op(1'b0, 2'd1, 8'h06, 32'h0, "R9");
    op(1'b0, 2'd0, 8'h04, 32'h0, "R9");
    op(1'b0, 2'd2, 8'h04, 32'h0, "R9");
    op(1'b1, 2'd1, 8'h0C, 32'h0000_0013, "R7");
    op(1'b0, 2'd1, 8'h0C, 32'h0, "R9");
    op(1'b0, 2'd1, 8'h0E, 32'h0, "R9");
    op(1'b0, 2'd2, 8'h0C, 32'h0, "R7");
    op(1'b1, 2'd1, 8'h0E, 32'h0000_0C3A, "R8");
    op(1'b0, 2'd1, 8'h04, 32'h0, "R8");
    op(1'b0, 2'd2, 8'h0C, 32'h0, "R8");
    op(1'b1, 2'd1, 8'h0E, 32'h0000_1111, "R8");
    stall = 1'b0;

    card_clk_hz = 32'd400_000;
    op(1'b1, 2'd2, 8'h30, 32'hCAFE_0001, "R10");
    card_clk_hz = 32'd300_000;
    op(1'b1, 2'd0, 8'h31, 32'h0000_0077, "R10");
    card_clk_hz = 32'd100_000;
    op(1'b1, 2'd1, 8'h06, 32'h0000_0010, "R10");
    op(1'b1, 2'd1, 8'h0C, 32'h0000_0021, "R10");
    op(1'b1, 2'd1, 8'h0E, 32'h0000_0D00, "R10");
    card_clk_hz = 32'd0;
    op(1'b1, 2'd2, 8'h34, 32'h1234_5678, "R11");
    op(1'b1, 2'd1, 8'h36, 32'h0000_9999, "R11");
    card_clk_hz = 32'd400_001;
    op(1'b1, 2'd2, 8'h38, 32'h0BAD_F00D, "R12");
    op(1'b1, 2'd1, 8'h04, 32'h0000_0001, "R12");
    op(1'b1, 2'd1, 8'h0E, 32'h0000_0002, "R12");

    card_clk_hz = 32'd25_000_000;
    op(1'b1, 2'd1, 8'h06, 32'h0000_4444, "R1");
    op(1'b1, 2'd1, 8'h0C, 32'h0000_5555, "R1");
    do_reset();
    op(1'b0, 2'd1, 8'h06, 32'h0, "R1");
    op(1'b0, 2'd1, 8'h0C, 32'h0, "R1");
    op(1'b1, 2'd1, 8'h0E, 32'h0000_6666, "R1");

    repeat (5) @(negedge clk);
    chk("R13", "pending downstream writes", 32'(wr_q.size()), 32'd0);
    chk("R13", "pending read responses", 32'(rd_q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule